// File: doc/BRIEF.md
# Power-on strap sampling controller

This controller governs a small group of dual-purpose pins. Each pin is read as a configuration input when power comes up and is then driven as a clock output. When the power-on reset input is released, the controller counts a fixed number of reference-clock cycles. During that interval every pin driver stays in high impedance, so an external pull resistor alone sets each pin's level. On the final cycle of the interval, the controller copies each synchronised pin level into a strap register and raises a valid flag. It then enables every pin driver.

When the drivers are first enabled, each clock output is held low. A pin's clock source passes through only after the controller has seen that source at a low level. As a result, the first high phase on the pin is always a full one. A hold-low input can force every clock output low at any time. The strap register and the valid flag are cleared only by the power-on reset. No other input can change them.

Top module: `strap_sampler`

## Requirements
- R1: `strap_valid` rises, and `strap_bits` load, on the `WIN_CYCLES`-th rising edge of `clk` at which `por_n` is sampled high after reset. The default `WIN_CYCLES` is 28636, which is 2 ms at 14.318 MHz.
- R2: `pin_oe` is all zeros while `por_n` is low and throughout the sampling interval, for every pin.
- R3: `strap_bits[i]` stores the level of `pin_in[i]` after a two-flop synchroniser. A pin pulled high stores 1 and a pin pulled low stores 0. The value captured is the one that `pin_in[i]` held at the rising edge two edges before the capture edge.
- R4: Once loaded, `strap_bits` stay unchanged whatever `pin_in`, `clk_src` or `hold_low` do. Only `por_n` low clears them to zero.
- R5: `strap_valid` stays high from the capture edge until `por_n` is next sampled low.
- R6: `pin_oe` goes to all ones on the same edge on which `strap_valid` rises. `pin_clk[i]` stays 0 until an edge at which the controller is already driving and `clk_src[i]` is sampled low.
- R7: Once a pin is released, `pin_clk[i]` equals the value of `clk_src[i]` sampled at the previous rising edge, one cycle late.
- R8: When `hold_low` is sampled high, every `pin_clk` bit is 0 after that edge. `pin_oe` and `strap_bits` are not affected.
- R9: While `por_n` is sampled low, every output is 0 after the edge. The reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; the only way to clear the straps |
| hold_low | input | 1 | Forces all clock outputs low |
| pin_in | input | NPIN | Levels read back from the dual-purpose pins |
| clk_src | input | NPIN | Clock level to be driven on each pin once released |
| pin_oe | output | NPIN | Per-pin driver enable (0 = high impedance) |
| pin_clk | output | NPIN | Per-pin clock data to the pad driver |
| strap_bits | output | NPIN | Latched configuration levels |
| strap_valid | output | 1 | High once the straps are latched |

## Verification
The hardest case to reach from the ports is a strap level that changes late in the interval. The capture must take the synchronised value, not the live one. The stimulus toggles `pin_in` during the interval and then settles it exactly two edges before the final edge. The reference model then shows whether the register took the value from two edges earlier. Each clock source runs at a different period, so its phase at the moment of enable differs from one power cycle to the next. This exercises both the case where the gate opens at once and the case where it must wait for a low phase. `hold_low` pulses and `pin_in` changes after the capture confirm that neither disturbs the latched bits.

// File: rtl/strap_pkg.sv
// Shared types for the strap sampling controller.
// Assumes nothing beyond a single clock domain.
package strap_pkg;
    // Two phases: pins are read as inputs, then driven as clocks.
    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_DRIVE  = 1'b1
    } strap_phase_t;
endpackage

// File: rtl/strap_sync.sv
// Two-flop synchroniser for the asynchronous pin levels.
// Assumes each pin level is quasi-static near the end of the interval.
module strap_sync #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_sync
);
    logic [NPIN-1:0] meta_q;
    logic [NPIN-1:0] stab_q;

    // Purpose: pass each pin level through two flops into the clk domain.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= pin_in;
            stab_q <= meta_q;
        end
    end

    assign pin_sync = stab_q;
endmodule

// File: rtl/strap_window.sv
// Interval timer. It counts reference cycles after power-on reset release
// and moves from the sampling phase to the driving phase.
// Assumes WIN_CYCLES >= 3, so that the synchroniser has filled before capture.
module strap_window
    import strap_pkg::*;
#(
    parameter int WIN_CYCLES = 28636
) (
    input  logic         clk,
    input  logic         por_n,
    output logic         capture,
    output strap_phase_t phase
);
    localparam int CW = $clog2(WIN_CYCLES) + 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    strap_phase_t  phase_q;

    // Purpose: flag the final cycle of the sampling interval.
    always_comb begin
        capture = (phase_q == PH_SAMPLE) && (cnt_q == LAST);
    end

    // Purpose: count the interval and hold in the drive phase afterwards.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q   <= '0;
            phase_q <= PH_SAMPLE;
        end else if (phase_q == PH_SAMPLE) begin
            if (capture) begin
                phase_q <= PH_DRIVE;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/strap_latch.sv
// Configuration latch. It loads the synchronised pin levels once per
// power cycle and keeps them until the next power-on reset.
// Assumes capture is a single-cycle pulse.
module strap_latch #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            capture,
    input  logic [NPIN-1:0] pin_sync,
    output logic [NPIN-1:0] bits,
    output logic            valid
);
    logic [NPIN-1:0] bits_q;
    logic            valid_q;

    // Purpose: one-time load of the strap levels; only the POR clears them.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            bits_q  <= '0;
            valid_q <= 1'b0;
        end else if (capture && !valid_q) begin
            bits_q  <= pin_sync;
            valid_q <= 1'b1;
        end
    end

    assign bits  = bits_q;
    assign valid = valid_q;
endmodule

// File: rtl/strap_clk_gate.sv
// Glitch-safe release of one pin's clock. The output stays low after the
// driver is enabled until the source is seen low, so the first high
// phase is never short. A hold-low input forces the output low.
// Assumes clk_src is a level that changes at most once per clk cycle.
module strap_clk_gate
    import strap_pkg::*;
(
    input  logic         clk,
    input  logic         por_n,
    input  strap_phase_t phase,
    input  logic         hold_low,
    input  logic         clk_src,
    output logic         pin_clk
);
    logic run_q;
    logic out_q;

    // Purpose: open the gate on the first low source level in the drive phase.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            run_q <= 1'b0;
        end else if (phase == PH_DRIVE && !clk_src) begin
            run_q <= 1'b1;
        end
    end

    // Purpose: register the gated, hold-able clock level for the pad.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= run_q && clk_src && !hold_low;
        end
    end

    assign pin_clk = out_q;
endmodule

// File: rtl/strap_sampler.sv
// Top of the strap sampling controller. It ties together the synchroniser,
// the interval timer, the configuration latch and one clock gate per pin.
// Assumes por_n is already synchronous to clk and is the only reset.
module strap_sampler
    import strap_pkg::*;
#(
    parameter int NPIN       = 2,
    parameter int WIN_CYCLES = 28636
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            hold_low,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] clk_src,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_clk,
    output logic [NPIN-1:0] strap_bits,
    output logic            strap_valid
);
    logic [NPIN-1:0] pin_sync;
    logic            capture;
    strap_phase_t    phase;

    strap_sync #(.NPIN(NPIN)) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    strap_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk     (clk),
        .por_n   (por_n),
        .capture (capture),
        .phase   (phase)
    );

    strap_latch #(.NPIN(NPIN)) u_latch (
        .clk      (clk),
        .por_n    (por_n),
        .capture  (capture),
        .pin_sync (pin_sync),
        .bits     (strap_bits),
        .valid    (strap_valid)
    );

    // Purpose: drivers are enabled for every pin once the drive phase starts.
    always_comb begin
        pin_oe = (phase == PH_DRIVE) ? '1 : '0;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        strap_clk_gate u_gate (
            .clk      (clk),
            .por_n    (por_n),
            .phase    (phase),
            .hold_low (hold_low),
            .clk_src  (clk_src[g]),
            .pin_clk  (pin_clk[g])
        );
    end
endmodule

// File: rtl/strap_sampler_chk.sv
// Property checker for strap_sampler, attached with bind.
// It counts cycles since reset release to check the interval length.
module strap_sampler_chk #(
    parameter int NPIN       = 2,
    parameter int WIN_CYCLES = 28636
) (
    input logic            clk,
    input logic            por_n,
    input logic            hold_low,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] pin_clk,
    input logic [NPIN-1:0] strap_bits,
    input logic            strap_valid
);
    localparam int CW = $clog2(WIN_CYCLES) + 2;
    localparam logic [CW-1:0] WIN = CW'(WIN_CYCLES);

    logic [CW-1:0] seen_q;

    // Purpose: saturating count of edges since the POR was released.
    always_ff @(posedge clk) begin
        if (!por_n) seen_q <= '0;
        else if (seen_q != WIN) seen_q <= seen_q + 1'b1;
    end

    assert_window_len_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(strap_valid) |-> (seen_q == WIN));
    assert_no_early_valid_R1: assert property (@(posedge clk) disable iff (!por_n)
        (seen_q != WIN) |-> !strap_valid);
    assert_tristate_in_window_R2: assert property (@(posedge clk) disable iff (!por_n)
        !strap_valid |-> (pin_oe == '0));
    assert_bits_frozen_R4: assert property (@(posedge clk) disable iff (!por_n)
        (strap_valid && $past(strap_valid)) |-> $stable(strap_bits));
    assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!por_n)
        strap_valid |=> strap_valid);
    assert_oe_with_valid_R6: assert property (@(posedge clk) disable iff (!por_n)
        strap_valid |-> (pin_oe == '1));
    assert_no_clk_undriven_R6: assert property (@(posedge clk) disable iff (!por_n)
        (pin_oe == '0) |-> (pin_clk == '0));
    assert_hold_forces_low_R8: assert property (@(posedge clk) disable iff (!por_n)
        hold_low |=> (pin_clk == '0));
endmodule

bind strap_sampler strap_sampler_chk #(
    .NPIN       (NPIN),
    .WIN_CYCLES (WIN_CYCLES)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .hold_low    (hold_low),
    .pin_oe      (pin_oe),
    .pin_clk     (pin_clk),
    .strap_bits  (strap_bits),
    .strap_valid (strap_valid)
);

// File: tb/test_strap_sampler.sv
// Bench: a behavioural reference model updated at each rising edge and
// compared with the design at each falling edge.
`timescale 1ns/1ps
module test_strap_sampler;
    localparam int NPIN = 2;
    localparam int WIN  = 20;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            hold_low = 1'b0;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] clk_src = '0;
    logic [NPIN-1:0] pin_oe, pin_clk, strap_bits;
    logic            strap_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    strap_sampler #(.NPIN(NPIN), .WIN_CYCLES(WIN)) i_strap_sampler (
        .clk(clk), .por_n(por_n), .hold_low(hold_low), .pin_in(pin_in),
        .clk_src(clk_src), .pin_oe(pin_oe), .pin_clk(pin_clk),
        .strap_bits(strap_bits), .strap_valid(strap_valid)
    );

    // Reference model state
    logic [NPIN-1:0] m_bits = '0, m_run = '0, m_clk = '0;
    logic            m_valid = 1'b0;
    int              m_cnt = 0;
    logic [NPIN-1:0] hist[$];

    always @(posedge clk) begin
        started = 1'b1;
        if (!por_n) begin
            m_bits = '0; m_run = '0; m_clk = '0; m_valid = 1'b0; m_cnt = 0;
            hist.delete();
        end else begin
            hist.push_back(pin_in);
            for (int i = 0; i < NPIN; i++) begin
                m_clk[i] = m_run[i] & clk_src[i] & ~hold_low;
                if (m_valid && !clk_src[i]) m_run[i] = 1'b1;
            end
            if (!m_valid) begin
                m_cnt++;
                if (m_cnt == WIN) begin
                    m_bits  = hist[hist.size()-3];
                    m_valid = 1'b1;
                end
            end
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            check(por_n ? "R3/R4" : "R9", "strap_bits", 32'(strap_bits), 32'(m_bits));
            check(por_n ? "R1/R5" : "R9", "strap_valid", 32'(strap_valid), 32'(m_valid));
            check(por_n ? "R2/R6" : "R9", "pin_oe", 32'(pin_oe), m_valid ? 32'(2'b11) : 32'(0));
            check(por_n ? "R6/R7/R8" : "R9", "pin_clk", 32'(pin_clk), 32'(m_clk));
        end
    end

    // Clock sources at different periods, so the phase at enable varies.
    int src_t = 0;
    always @(negedge clk) begin
        src_t++;
        clk_src[0] <= (src_t % 4) >= 2;
        clk_src[1] <= (src_t % 6) >= 3;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // One power cycle: reset, hold the strap level, run after capture.
    task automatic power_cycle(logic [NPIN-1:0] lvl, int extra);
        por_n = 1'b0; cyc(3);
        por_n = 1'b1; pin_in = lvl;
        cyc(WIN + extra);
    endtask

    initial begin
        // R9: reset state, checked each cycle while por_n is low
        cyc(4);
        // R1 R3: each strap combination, with different enable phases (R6 R7)
        power_cycle(2'b01, 10);
        power_cycle(2'b10, 11);
        power_cycle(2'b11, 13);
        power_cycle(2'b00, 9);
        // R3: level toggles mid-window and settles two edges before capture
        por_n = 1'b0; cyc(3); por_n = 1'b1;
        for (int k = 0; k < WIN - 3; k++) begin
            pin_in = NPIN'(k); cyc(1);
        end
        pin_in = 2'b10; cyc(1);
        pin_in = 2'b01; cyc(8);
        // R4 R8: straps ignore later pin changes and hold_low pulses
        pin_in = 2'b11; cyc(3);
        hold_low = 1'b1; cyc(5);
        pin_in = 2'b00;
        hold_low = 1'b0; cyc(6);
        hold_low = 1'b1; cyc(1); hold_low = 1'b0; cyc(5);
        // R5 R9: power-on reset in the middle of a window, then a full one
        por_n = 1'b0; cyc(2); por_n = 1'b1; pin_in = 2'b11; cyc(WIN / 2);
        por_n = 1'b0; cyc(2); por_n = 1'b1; pin_in = 2'b10; cyc(WIN + 12);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule